// File: doc/BRIEF.md
# Signed Integer Divide Unit

This block is a register-mapped divide engine for a processor subsystem. Software writes a numerator, a denominator and a width mode. The unit then produces a signed quotient that truncates toward zero, and a remainder that takes the sign of the numerator. Each operand is 64 bits wide and sits in two 32-bit words. The control word carries the width mode, an error flag and a busy flag.

Any write to the numerator, to the denominator or to the control word starts a new computation. Software polls the busy flag, which stays set for a fixed number of cycles. The previous results stay readable until the new ones are committed. A zero denominator, and the case of the most negative value divided by minus one, produce fixed results and raise the error flag.

Top module: `sdiv_regblock`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero: mode 0, error 0 and busy 0.
- R2: The word map is: index 0 is control, 1 and 2 are the numerator low and high words, 3 and 4 are the denominator low and high, 5 and 6 are the quotient low and high, and 7 and 8 are the remainder low and high. The lower index always holds bits 31:0.
- R3: Control bits 1:0 select the mode. In mode 0 both operands are their low 32 bits sign-extended. In modes 1 and 3 the numerator is the full 64 bits and the denominator is its low 32 bits sign-extended. In mode 2 both operands are the full 64 bits.
- R4: A write to index 0, 1, 2, 3 or 4 sets control bit 15 (busy), which reads 1 from the next cycle. Busy clears exactly 66 clock edges after the last such write. A write made while busy restarts the count.
- R5: While busy is set, the quotient, remainder and error bit keep their previous values.
- R6: With a nonzero denominator and no overflow, the unit stores the truncated quotient and a remainder with the numerator's sign, and it clears control bit 14.
- R7: With a zero extended denominator, the unit sets bit 14, the remainder receives the extended numerator, and the quotient becomes 1 for a negative numerator and 0 otherwise.
- R8: With an extended numerator of 0x8000000000000000 and an extended denominator of -1, the unit sets bit 14, the quotient receives the numerator, and the remainder is left unchanged.
- R9: Only control bits 1:0 are writable. Writes to the result words (indices 5 to 8) change nothing and start nothing.
- R10: Indices 9 to 15 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the index |

## Verification
A fault in the sequencer or the iteration counter shows up on the busy bit of the control word in the very cycle the count drifts, because the reference is compared on every clock. A wrong partial remainder or sign fix-up stays hidden until the commit edge. It then appears at once as a wrong quotient or remainder word, 66 cycles after the write. A wrong special-case decision shows up at the same moment in bit 14, or in a remainder that was overwritten when it should have been kept.

// File: rtl/sdiv_pkg.sv
// Shared constants and types for the signed divide unit.
// Assumes a 32-bit register bus carrying 64-bit operands as word pairs.
package sdiv_pkg;
    localparam int DATA_W = 64;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] REG_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] REG_NUM_LO = 4'd1;
    localparam logic [ADDR_W-1:0] REG_NUM_HI = 4'd2;
    localparam logic [ADDR_W-1:0] REG_DEN_LO = 4'd3;
    localparam logic [ADDR_W-1:0] REG_DEN_HI = 4'd4;
    localparam logic [ADDR_W-1:0] REG_QUO_LO = 4'd5;
    localparam logic [ADDR_W-1:0] REG_QUO_HI = 4'd6;
    localparam logic [ADDR_W-1:0] REG_REM_LO = 4'd7;
    localparam logic [ADDR_W-1:0] REG_REM_HI = 4'd8;

    localparam int CTRL_BUSY_BIT = 15;
    localparam int CTRL_ERR_BIT  = 14;

    typedef enum logic [1:0] {
        MODE_NARROW   = 2'd0,
        MODE_MIXED_A  = 2'd1,
        MODE_WIDE     = 2'd2,
        MODE_MIXED_B  = 2'd3
    } div_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RUN,
        ST_COMMIT
    } seq_state_e;
endpackage

// File: rtl/sdiv_operand_prep.sv
// Operand preparation: applies the width mode, sign-extends the narrow
// operands, forms unsigned magnitudes and flags the two special cases.
// Purely combinational. Assumes DW is even.
module sdiv_operand_prep
    import sdiv_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  div_mode_e        mode,
    input  logic [DW-1:0]    num_raw,
    input  logic [DW-1:0]    den_raw,
    output logic [DW-1:0]    num_ext,
    output logic [DW-1:0]    num_mag,
    output logic [DW-1:0]    den_mag,
    output logic             num_neg,
    output logic             den_neg,
    output logic             den_zero,
    output logic             ovf
);
    localparam int HW = DW / 2;
    localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] den_ext;
    logic [DW-1:0] num_narrow;
    logic [DW-1:0] den_narrow;

    assign num_narrow = {{HW{num_raw[HW-1]}}, num_raw[HW-1:0]};
    assign den_narrow = {{HW{den_raw[HW-1]}}, den_raw[HW-1:0]};

    // Select the extended operands for the current mode.
    always_comb begin
        num_ext = (mode == MODE_NARROW) ? num_narrow : num_raw;
        den_ext = (mode == MODE_WIDE)   ? den_raw    : den_narrow;
    end

    // Signs, magnitudes and special-case flags.
    always_comb begin
        num_neg  = num_ext[DW-1];
        den_neg  = den_ext[DW-1];
        num_mag  = num_neg ? (~num_ext + 1'b1) : num_ext;
        den_mag  = den_neg ? (~den_ext + 1'b1) : den_ext;
        den_zero = (den_ext == '0);
        ovf      = (num_ext == MOST_NEG) && (den_ext == '1);
    end
endmodule

// File: rtl/sdiv_core.sv
// Restoring unsigned divider: one quotient bit per clock, DW steps after
// a start pulse. The magnitudes must stay stable from start until last.
module sdiv_core #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic [DW-1:0] quotient,
    output logic [DW-1:0] remainder,
    output logic          last
);
    localparam int CW = $clog2(DW + 1);

    logic [DW-1:0] part_q;
    logic [DW-1:0] quo_q;
    logic [CW-1:0] cnt_q;
    logic [DW:0]   shifted;
    logic [DW:0]   trial;
    logic          fits;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        shifted = {part_q, quo_q[DW-1]};
        trial   = shifted - {1'b0, divisor};
        fits    = ~trial[DW];
    end

    // Iteration registers: load on start, then shift in one bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
        end else if (start) begin
            part_q <= '0;
            quo_q  <= dividend;
            cnt_q  <= CW'(DW);
        end else if (cnt_q != '0) begin
            part_q <= fits ? trial[DW-1:0] : shifted[DW-1:0];
            quo_q  <= {quo_q[DW-2:0], fits};
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign quotient  = quo_q;
    assign remainder = part_q;
    assign last      = (cnt_q == CW'(1));
endmodule

// File: rtl/sdiv_result_fix.sv
// Result shaping: restores signs on the unsigned results and substitutes
// the fixed results for the zero-denominator and overflow cases.
// Purely combinational.
module sdiv_result_fix #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] quo_mag,
    input  logic [DW-1:0] rem_mag,
    input  logic [DW-1:0] num_ext,
    input  logic          num_neg,
    input  logic          den_neg,
    input  logic          den_zero,
    input  logic          ovf,
    output logic [DW-1:0] quo_val,
    output logic [DW-1:0] rem_val,
    output logic          rem_we,
    output logic          err
);
    logic [DW-1:0] quo_signed;
    logic [DW-1:0] rem_signed;

    // Sign correction: quotient by sign difference, remainder by numerator.
    always_comb begin
        quo_signed = (num_neg ^ den_neg) ? (~quo_mag + 1'b1) : quo_mag;
        rem_signed = num_neg ? (~rem_mag + 1'b1) : rem_mag;
    end

    // Special-case override, zero denominator first.
    always_comb begin
        if (den_zero) begin
            quo_val = {{(DW-1){1'b0}}, num_neg};
            rem_val = num_ext;
            rem_we  = 1'b1;
            err     = 1'b1;
        end else if (ovf) begin
            quo_val = num_ext;
            rem_val = rem_signed;
            rem_we  = 1'b0;
            err     = 1'b1;
        end else begin
            quo_val = quo_signed;
            rem_val = rem_signed;
            rem_we  = 1'b1;
            err     = 1'b0;
        end
    end
endmodule

// File: rtl/sdiv_regblock.sv
// Register-mapped signed divider. Holds the control, operand and result
// words, sequences one divide per operand or control write, and commits
// the results DW+2 edges after the last such write.
// Assumes a single-cycle bus write and combinational reads.
module sdiv_regblock
    import sdiv_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DW/2-1:0]     bus_wdata,
    output logic [DW/2-1:0]     bus_rdata
);
    localparam int HW = DW / 2;
    localparam int N_OPND = 2;

    div_mode_e     mode_q;
    logic          err_q;
    seq_state_e    state_q;
    logic [DW-1:0] opnd_q [N_OPND];
    logic [DW-1:0] quo_q;
    logic [DW-1:0] rem_q;

    logic          wr;
    logic          restart;
    logic          busy;

    logic [DW-1:0] prep_num_ext, prep_num_mag, prep_den_mag;
    logic          prep_num_neg, prep_den_neg, prep_den_zero, prep_ovf;
    logic [DW-1:0] core_quo, core_rem;
    logic          core_last;
    logic [DW-1:0] fix_quo, fix_rem;
    logic          fix_rem_we, fix_err;

    assign wr      = bus_sel & bus_wr;
    assign restart = wr && (bus_addr <= REG_DEN_HI);
    assign busy    = (state_q != ST_IDLE);

    // Operand word pairs: numerator (0) and denominator (1).
    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        localparam logic [ADDR_W-1:0] LO_IDX = ADDR_W'(1 + 2 * g);
        localparam logic [ADDR_W-1:0] HI_IDX = ADDR_W'(2 + 2 * g);
        // Capture bus writes into the low or high half of this operand.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                opnd_q[g] <= '0;
            end else if (wr && bus_addr == LO_IDX) begin
                opnd_q[g][HW-1:0] <= bus_wdata;
            end else if (wr && bus_addr == HI_IDX) begin
                opnd_q[g][DW-1:HW] <= bus_wdata;
            end
        end
    end

    // Mode field: the only writable part of the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_NARROW;
        end else if (wr && bus_addr == REG_CTRL) begin
            mode_q <= div_mode_e'(bus_wdata[1:0]);
        end
    end

    // Sequencer: restart on any operand or control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (restart) begin
            state_q <= ST_LOAD;
        end else begin
            unique case (state_q)
                ST_LOAD:   state_q <= ST_RUN;
                ST_RUN:    state_q <= core_last ? ST_COMMIT : ST_RUN;
                ST_COMMIT: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Result commit; a restart on the commit edge discards the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            err_q <= 1'b0;
        end else if (state_q == ST_COMMIT && !restart) begin
            quo_q <= fix_quo;
            err_q <= fix_err;
            if (fix_rem_we) begin
                rem_q <= fix_rem;
            end
        end
    end

    sdiv_operand_prep #(.DW(DW)) u_prep (
        .mode     (mode_q),
        .num_raw  (opnd_q[0]),
        .den_raw  (opnd_q[1]),
        .num_ext  (prep_num_ext),
        .num_mag  (prep_num_mag),
        .den_mag  (prep_den_mag),
        .num_neg  (prep_num_neg),
        .den_neg  (prep_den_neg),
        .den_zero (prep_den_zero),
        .ovf      (prep_ovf)
    );

    sdiv_core #(.DW(DW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (state_q == ST_LOAD && !restart),
        .dividend  (prep_num_mag),
        .divisor   (prep_den_mag),
        .quotient  (core_quo),
        .remainder (core_rem),
        .last      (core_last)
    );

    sdiv_result_fix #(.DW(DW)) u_fix (
        .quo_mag  (core_quo),
        .rem_mag  (core_rem),
        .num_ext  (prep_num_ext),
        .num_neg  (prep_num_neg),
        .den_neg  (prep_den_neg),
        .den_zero (prep_den_zero),
        .ovf      (prep_ovf),
        .quo_val  (fix_quo),
        .rem_val  (fix_rem),
        .rem_we   (fix_rem_we),
        .err      (fix_err)
    );

    // Read multiplexer over the word map.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_CTRL: begin
                bus_rdata[1:0]           = mode_q;
                bus_rdata[CTRL_ERR_BIT]  = err_q;
                bus_rdata[CTRL_BUSY_BIT] = busy;
            end
            REG_NUM_LO: bus_rdata = opnd_q[0][HW-1:0];
            REG_NUM_HI: bus_rdata = opnd_q[0][DW-1:HW];
            REG_DEN_LO: bus_rdata = opnd_q[1][HW-1:0];
            REG_DEN_HI: bus_rdata = opnd_q[1][DW-1:HW];
            REG_QUO_LO: bus_rdata = quo_q[HW-1:0];
            REG_QUO_HI: bus_rdata = quo_q[DW-1:HW];
            REG_REM_LO: bus_rdata = rem_q[HW-1:0];
            REG_REM_HI: bus_rdata = rem_q[DW-1:HW];
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sdiv_checker.sv
// Property checker for the divide unit, bound into every sdiv_regblock.
// Observes the bus, the sequencer's busy state and the committed results.
module sdiv_checker
    import sdiv_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        wdata_mode,
    input logic [1:0]        mode,
    input logic              restart,
    input logic              busy,
    input logic              err,
    input logic [DW-1:0]     quo,
    input logic [DW-1:0]     num_ext,
    input logic              den_zero,
    input logic              ovf
);
    localparam int LW = $clog2(DW + 4) + 1;

    logic [LW-1:0] since_write;

    // Counts the edges since the last restarting write while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_write <= '0;
        end else if (restart) begin
            since_write <= LW'(1);
        end else if (busy) begin
            since_write <= since_write + 1'b1;
        end
    end

    a_r4_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> busy);

    // The first sample after the fall sees the counter at DW+3.
    a_r4_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> since_write == LW'(DW + 3));

    a_r5_results_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($stable(quo) && $stable(err)));

    a_r6_normal_clears_error: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !den_zero && !ovf) |-> !err);

    a_r7_zero_sets_error: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && den_zero) |-> err);

    a_r8_overflow_result: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && ovf && !den_zero) |-> (err && quo == num_ext));

    a_r9_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == REG_CTRL) |=> mode == $past(wdata_mode));
endmodule

bind sdiv_regblock sdiv_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .wdata_mode (bus_wdata[1:0]),
    .mode       (mode_q),
    .restart    (restart),
    .busy       (busy),
    .err        (err_q),
    .quo        (quo_q),
    .num_ext    (prep_num_ext),
    .den_zero   (prep_den_zero),
    .ovf        (prep_ovf)
);

// File: tb/sim_sdiv_regblock.sv
// Bench for sdiv_regblock: a behavioural reference of the register file
// and divide timing, compared against the read port on every clock.
module sim_sdiv_regblock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    sdiv_regblock u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Reference state.
    logic [1:0]  m_mode;
    logic        m_err, m_busy;
    int          m_cnt;
    logic [63:0] m_num, m_den, m_quo, m_rem;

    task automatic model_commit();
        longint n, d;
        n = (m_mode == 2'd0) ? longint'($signed(m_num[31:0])) : longint'(m_num);
        d = (m_mode == 2'd2) ? longint'(m_den) : longint'($signed(m_den[31:0]));
        if (d == 0) begin
            m_err = 1'b1; m_rem = n; m_quo = (n < 0) ? 64'd1 : 64'd0;
        end else if (n == longint'(64'h8000_0000_0000_0000) && d == -1) begin
            m_err = 1'b1; m_quo = n;
        end else begin
            m_err = 1'b0; m_quo = n / d; m_rem = n % d;
        end
    endtask

    // Reference update on each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_err = 0; m_busy = 0; m_cnt = 0;
            m_num = 0; m_den = 0; m_quo = 0; m_rem = 0;
        end else begin
            logic rs;
            rs = bus_sel && bus_wr && bus_addr <= 4'd4;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0;
                    if (!rs) model_commit();
                end
            end
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    4'd0: m_mode = bus_wdata[1:0];
                    4'd1: m_num[31:0] = bus_wdata;
                    4'd2: m_num[63:32] = bus_wdata;
                    4'd3: m_den[31:0] = bus_wdata;
                    4'd4: m_den[63:32] = bus_wdata;
                    default: ;
                endcase
            end
            if (rs) begin
                m_busy = 1; m_cnt = 66;
            end
        end
    end

    function automatic logic [31:0] exp_read(logic [3:0] a);
        case (a)
            4'd0: return {16'd0, m_busy, m_err, 12'd0, m_mode};
            4'd1: return m_num[31:0];
            4'd2: return m_num[63:32];
            4'd3: return m_den[31:0];
            4'd4: return m_den[63:32];
            4'd5: return m_quo[31:0];
            4'd6: return m_quo[63:32];
            4'd7: return m_rem[31:0];
            4'd8: return m_rem[63:32];
            default: return 32'd0;
        endcase
    endfunction

    // Per-clock comparison of the read port with the reference.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] e;
            e = exp_read(bus_addr);
            vectors++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s index %0d: actual=%h expected=%h",
                         (bus_addr == 0) ? "R4" : (bus_addr >= 5 && bus_addr <= 8) ? "R6" : "R2",
                         bus_addr, bus_rdata, e);
            end
        end
    end

    task automatic put(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic chk(input logic [3:0] a, input logic [31:0] e, input string tag);
        @(negedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        vectors++;
        if (bus_rdata !== e) begin
            fails++;
            $display("FAIL %s index %0d: actual=%h expected=%h", tag, a, bus_rdata, e);
        end
    endtask

    task automatic chk_now(input logic [31:0] e, input string tag);
        vectors++;
        if (bus_rdata !== e) begin
            fails++;
            $display("FAIL %s index %0d: actual=%h expected=%h", tag, bus_addr, bus_rdata, e);
        end
    endtask

    task automatic run_div(input logic [1:0] md, input logic [63:0] n, input logic [63:0] d);
        put(4'd1, n[31:0]); put(4'd2, n[63:32]);
        put(4'd3, d[31:0]); put(4'd4, d[63:32]);
        put(4'd0, {30'd0, md});
        repeat (70) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL R4 watchdog: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1;
        // R1: reset state
        chk(4'd0, 32'h0, "R1");
        chk(4'd5, 32'h0, "R1");
        chk(4'd8, 32'h0, "R1");

        // R3 R6: mode 0, -7 / 2 with junk in high words
        run_div(2'd0, 64'h0000_1234_FFFF_FFF9, 64'h0000_5678_0000_0002);
        chk(4'd5, 32'hFFFF_FFFD, "R6");
        chk(4'd6, 32'hFFFF_FFFF, "R3");
        chk(4'd7, 32'hFFFF_FFFF, "R6");
        chk(4'd0, 32'h0000_0000, "R6");

        // R4 R5: latency and held results after one numerator write (100/2)
        put(4'd1, 32'd100);
        bus_addr = 4'd5;
        repeat (10) @(negedge clk);
        chk_now(32'hFFFF_FFFD, "R5");
        #1 bus_addr = 4'd0;
        repeat (55) @(negedge clk);
        chk_now(32'h0000_8000, "R4");
        @(negedge clk);
        chk_now(32'h0000_0000, "R4");
        chk(4'd5, 32'd50, "R6");

        // R4: restart while busy (1000 / 10)
        put(4'd1, 32'd1000);
        repeat (30) @(negedge clk);
        put(4'd3, 32'd10);
        bus_addr = 4'd0;
        repeat (65) @(negedge clk);
        chk_now(32'h0000_8000, "R4");
        @(negedge clk);
        chk_now(32'h0000_0000, "R4");
        chk(4'd5, 32'd100, "R4");

        // R6: wide mode, mixed signs
        run_div(2'd2, 64'hFFFF_FEDC_BA98_7655, 64'h0000_0000_0001_2345);
        chk(4'd5, exp_read(4'd5), "R6");
        chk(4'd8, exp_read(4'd8), "R6");

        // R3: mixed modes ignore the denominator high word
        run_div(2'd1, 64'hFFFF_FFFF_FFFF_FF9C, 64'h0000_0005_FFFF_FFF9);
        chk(4'd5, 32'd14, "R3");
        chk(4'd7, 32'hFFFF_FFFE, "R3");
        run_div(2'd3, 64'h0000_0001_0000_0000, 64'hABCD_0000_0000_0010);
        chk(4'd5, 32'h1000_0000, "R3");
        chk(4'd6, 32'h0, "R3");

        // R7: zero denominator, negative and positive numerator
        run_div(2'd2, 64'hFFFF_FFFF_FFFF_FFFB, 64'h0);
        chk(4'd0, 32'h0000_4002, "R7");
        chk(4'd5, 32'd1, "R7");
        chk(4'd7, 32'hFFFF_FFFB, "R7");
        run_div(2'd0, 64'h0000_0000_0000_0009, 64'h0000_0005_0000_0000);
        chk(4'd0, 32'h0000_4000, "R7");
        chk(4'd5, 32'd0, "R7");
        chk(4'd7, 32'd9, "R7");

        // R8: overflow keeps the old remainder (9)
        run_div(2'd1, 64'h8000_0000_0000_0000, 64'h1111_1111_FFFF_FFFF);
        chk(4'd0, 32'h0000_4001, "R8");
        chk(4'd6, 32'h8000_0000, "R8");
        chk(4'd7, 32'd9, "R8");
        // R8: narrow most-negative by -1 is not an overflow
        run_div(2'd0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF);
        chk(4'd0, 32'h0000_0000, "R8");
        chk(4'd5, 32'h8000_0000, "R8");
        chk(4'd6, 32'h0000_0000, "R8");

        // R9: result words are read-only and start nothing
        put(4'd5, 32'hDEAD_BEEF);
        chk(4'd0, 32'h0000_0000, "R9");
        chk(4'd5, 32'h8000_0000, "R9");
        // R9: only mode bits take a control write
        put(4'd0, 32'hFFFF_C002);
        chk(4'd0, 32'h0000_8002, "R9");
        repeat (70) @(negedge clk);

        // R10: unmapped index
        put(4'd12, 32'h1234_5678);
        chk(4'd12, 32'h0, "R10");
        chk(4'd0, 32'h0000_0002, "R10");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule